// File: doc/BRIEF.md
# Masked-address GPIO port

This block is an eight-line general-purpose I/O port that sits behind a simple 32-bit, word-aligned register bus inside a 4 KB address window. It holds a direction register, an alternate-function select register and the output data for the lines. It drives output values and output enables toward the pads, and it brings the external pin levels in through a two-stage synchronizer.

The data register is reached through a 256-word aliased window. Address bits [9:2] of each access act as a per-bit mask. A read returns only the masked bits. A write changes only the masked bits. Software can therefore set or clear a single line with one store and no read-modify-write. The top of the window answers eight fixed identification bytes.

Interrupt detection is not part of this block. The block hands the synchronized pin state and a select strobe for the interrupt register range to a separate unit.

Top module: `gpio_mask_port`

## Requirements
- R1: A synchronous active-high reset clears direction, alternate select, held output data, read data and the synchronizer, so every line starts as an input driving 0.
- R2: A read anywhere in byte offsets 0x000–0x3FC returns the pin view ANDed with address bits [9:2] in read data bits [7:0], one clock after the request. For a line with direction 1 the pin view is the held output bit. For a line with direction 0 it is the synchronized input bit.
- R3: A write in 0x000–0x3FC updates only the held output bits whose address-mask bit is 1. All other held bits keep their value.
- R4: Offset 0x400 is the direction register, with 1 meaning output. It reads back, and `pin_oe` mirrors it.
- R5: A data write leaves the held output bit of every line that is an input at write time unchanged. This shows on `pin_out` once the line is later made an output.
- R6: Offset 0x420 is a plain read/write alternate-select register, driven on `alt_sel`.
- R7: Reads of 0xFE0, 0xFE4, 0xFE8 and 0xFEC return 0x61, 0x10, 0x04 and 0x00. Reads of 0xFF0, 0xFF4, 0xFF8 and 0xFFC return 0x0D, 0xF0, 0x05 and 0xB1.
- R8: Reads of unmapped offsets return 0, and writes to them change no register. `bus_rdata` holds its value in any cycle without a read.
- R9: Bits [31:8] of every read are 0, and only `bus_wdata[7:0]` of a write is used.
- R10: A change on `pin_in` appears on `pin_state` and in data reads after exactly two clock edges.
- R11: `ext_sel` is high, combinationally, while a valid access targets 0x404–0x41C. That range reads 0 from this block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 8 | External pin levels (asynchronous) |
| pin_out | output | 8 | Output values toward the pads |
| pin_oe | output | 8 | Output enables toward the pads |
| alt_sel | output | 8 | Alternate-function select per line |
| pin_state | output | 8 | Synchronized pin levels for the interrupt unit |
| ext_sel | output | 1 | Access targets the interrupt register range |

## Verification
The case hardest to reach from the ports is a data write that lands on lines configured as inputs. Its effect is hidden, because reads of those lines show the synchronized pins rather than the held value. The bench writes all-ones data while the upper lines are inputs. It then turns those lines into outputs and checks that `pin_out` still shows the old value. The vector table also mixes narrow address masks with a fixed external pattern, so every read returns a blend of held and sampled bits.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DATA,
    SEL_DIR,
    SEL_ALT,
    SEL_ID,
    SEL_EXT
  } gpio_sel_e;

  // Fixed identification bytes, indexed by {addr[4], addr[3:2]}
  function automatic logic [7:0] ident_byte(input logic [2:0] idx);
    logic [7:0] v;
    case (idx)
      3'd0: v = 8'h61;
      3'd1: v = 8'h10;
      3'd2: v = 8'h04;
      3'd3: v = 8'h00;
      3'd4: v = 8'h0D;
      3'd5: v = 8'hF0;
      3'd6: v = 8'h05;
      default: v = 8'hB1;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_mask_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int PINS   = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output gpio_sel_e         sel,
  output logic [2:0]        id_idx
);
  localparam int MASK_MSB = PINS + 1;
  localparam int WORD_W   = ADDR_W - 2;
  localparam logic [WORD_W-1:0] W_DIR     = WORD_W'(10'h100);
  localparam logic [WORD_W-1:0] W_ALT     = WORD_W'(10'h108);
  localparam logic [WORD_W-1:0] W_EXT_LO  = WORD_W'(10'h101);
  localparam logic [WORD_W-1:0] W_EXT_HI  = WORD_W'(10'h107);

  logic [WORD_W-1:0] word;
  assign word   = addr[ADDR_W-1:2];
  assign id_idx = {addr[4], addr[3:2]};

  always_comb begin
    sel = SEL_NONE;
    if (addr[ADDR_W-1:MASK_MSB+1] == '0)
      sel = SEL_DATA;
    else if (word == W_DIR)
      sel = SEL_DIR;
    else if (word == W_ALT)
      sel = SEL_ALT;
    else if (word >= W_EXT_LO && word <= W_EXT_HI)
      sel = SEL_EXT;
    else if (addr[ADDR_W-1:5] == '1)
      sel = SEL_ID;
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int PINS   = 8,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] d,
  output logic [PINS-1:0] q
);
  logic [PINS-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= '0;
    else     stage[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[s] <= '0;
      else     stage[s] <= stage[s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
  import gpio_mask_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  gpio_sel_e       sel,
  input  logic [PINS-1:0] mask,
  input  logic [PINS-1:0] wdata,
  output logic [PINS-1:0] dir_q,
  output logic [PINS-1:0] alt_q,
  output logic [PINS-1:0] out_q
);
  logic [PINS-1:0] upd;
  assign upd = mask & dir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
      alt_q <= '0;
      out_q <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_DATA: out_q <= (out_q & ~upd) | (wdata & upd);
        SEL_DIR:  dir_q <= wdata;
        SEL_ALT:  alt_q <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_mask_pkg::*;
#(
  parameter int PINS        = 8,
  parameter int ADDR_W      = 12,
  parameter int BUS_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe,
  output logic [PINS-1:0]   alt_sel,
  output logic [PINS-1:0]   pin_state,
  output logic              ext_sel
);
  localparam int MASK_MSB = PINS + 1;

  gpio_sel_e       sel;
  logic [2:0]      id_idx;
  logic [PINS-1:0] mask;
  logic [PINS-1:0] dir_q, alt_q, out_q, sync_q, view, rd_next;
  logic            unused_bits;

  assign mask        = bus_addr[MASK_MSB:2];
  assign unused_bits = ^{bus_wdata[BUS_W-1:PINS], bus_addr[1:0]};

  gpio_addr_dec #(.ADDR_W(ADDR_W), .PINS(PINS)) u_dec (
    .addr(bus_addr), .sel(sel), .id_idx(id_idx)
  );

  gpio_in_sync #(.PINS(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(sync_q)
  );

  gpio_ctrl_regs #(.PINS(PINS)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(bus_valid && bus_write),
    .sel(sel), .mask(mask), .wdata(bus_wdata[PINS-1:0]),
    .dir_q(dir_q), .alt_q(alt_q), .out_q(out_q)
  );

  // Outputs show held data, inputs show synchronized pins
  assign view = (dir_q & out_q) | (~dir_q & sync_q);

  always_comb begin
    case (sel)
      SEL_DATA: rd_next = view & mask;
      SEL_DIR:  rd_next = dir_q;
      SEL_ALT:  rd_next = alt_q;
      SEL_ID:   rd_next = PINS'(ident_byte(id_idx));
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else if (bus_valid && !bus_write)
      bus_rdata <= {{(BUS_W-PINS){1'b0}}, rd_next};
  end

  assign pin_out   = out_q;
  assign pin_oe    = dir_q;
  assign alt_sel   = alt_q;
  assign pin_state = sync_q;
  assign ext_sel   = bus_valid && (sel == SEL_EXT);
endmodule

// File: rtl/gpio_mask_port_chk.sv
module gpio_mask_port_chk #(
  parameter int PINS   = 8,
  parameter int ADDR_W = 12,
  parameter int BUS_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic [PINS-1:0]   pin_out,
  input logic [PINS-1:0]   pin_oe,
  input logic [PINS-1:0]   alt_sel
);
  localparam int MASK_MSB = PINS + 1;

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (pin_oe == '0 && pin_out == '0 && alt_sel == '0 && bus_rdata == '0));

  a_r3_unmasked_hold: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_write && bus_addr[ADDR_W-1:MASK_MSB+1] == '0)
    |=> (((pin_out ^ $past(pin_out)) & ~$past(bus_addr[MASK_MSB:2])) == '0));

  a_r5_input_lines_hold: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((pin_out ^ $past(pin_out)) & ~$past(pin_oe)) == '0));

  a_r6_alt_only_on_write: assert property (@(posedge clk) disable iff (rst)
    !(bus_valid && bus_write) |=> $stable(alt_sel));

  a_r8_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !(bus_valid && !bus_write) |=> $stable(bus_rdata));

  a_r9_upper_zero: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[BUS_W-1:PINS] == '0);
endmodule

bind gpio_mask_port gpio_mask_port_chk #(.PINS(PINS), .ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .pin_out(pin_out),
  .pin_oe(pin_oe), .alt_sel(alt_sel)
);

// File: tb/gpio_mask_port_bench.sv
`timescale 1ns/1ps
module gpio_mask_port_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  pin_in = 8'h00;
  logic [7:0]  pin_out, pin_oe, alt_sel, pin_state;
  logic        ext_sel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_mask_port u_gpio_mask_port (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .alt_sel(alt_sel),
    .pin_state(pin_state), .ext_sel(ext_sel)
  );

  // {write, addr, wdata, expected read byte}
  localparam int NV = 24;
  localparam logic [28:0] VEC [NV] = '{
    {1'b1, 12'h400, 8'h0F, 8'h00},
    {1'b1, 12'h3FC, 8'h3C, 8'h00},
    {1'b0, 12'h3FC, 8'h00, 8'hAC},
    {1'b0, 12'h028, 8'h00, 8'h08},
    {1'b1, 12'h004, 8'hFF, 8'h00},
    {1'b0, 12'h3FC, 8'h00, 8'hAD},
    {1'b1, 12'h010, 8'h00, 8'h00},
    {1'b0, 12'h3FC, 8'h00, 8'hA9},
    {1'b0, 12'h400, 8'h00, 8'h0F},
    {1'b1, 12'h420, 8'h5A, 8'h00},
    {1'b0, 12'h420, 8'h00, 8'h5A},
    {1'b0, 12'hFE0, 8'h00, 8'h61},
    {1'b0, 12'hFE4, 8'h00, 8'h10},
    {1'b0, 12'hFE8, 8'h00, 8'h04},
    {1'b0, 12'hFEC, 8'h00, 8'h00},
    {1'b0, 12'hFF0, 8'h00, 8'h0D},
    {1'b0, 12'hFF4, 8'h00, 8'hF0},
    {1'b0, 12'hFF8, 8'h00, 8'h05},
    {1'b0, 12'hFFC, 8'h00, 8'hB1},
    {1'b0, 12'h500, 8'h00, 8'h00},
    {1'b1, 12'h800, 8'hFF, 8'h00},
    {1'b0, 12'h400, 8'h00, 8'h0F},
    {1'b0, 12'h420, 8'h00, 8'h5A},
    {1'b0, 12'h404, 8'h00, 8'h00}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  function automatic string req_of(input logic [11:0] a);
    if (a < 12'h400)                     return "R2";
    if (a == 12'h400)                    return "R4";
    if (a == 12'h420)                    return "R6";
    if (a >= 12'hFE0)                    return "R7";
    if (a >= 12'h404 && a <= 12'h41C)    return "R11";
    return "R8";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    // R1: state during reset
    check("R1 pin_out", {24'h0, pin_out}, 32'h0);
    check("R1 pin_oe", {24'h0, pin_oe}, 32'h0);
    check("R1 alt_sel", {24'h0, alt_sel}, 32'h0);
    check("R1 rdata", bus_rdata, 32'h0);
    rst = 1'b0;
    pin_in = 8'hA5;
    repeat (3) @(negedge clk);

    // Vector table; R9: upper bits compared as zero on every read
    for (int i = 0; i < NV; i++) begin
      logic [28:0] v;
      v = VEC[i];
      if (v[28]) bus_wr(v[27:16], {24'hFFFF00, v[15:8]});
      else begin
        bus_rd(v[27:16], rd);
        check(req_of(v[27:16]), rd, {24'h0, v[7:0]});
      end
    end
    check("R3 pin_out", {24'h0, pin_out}, 32'h09);
    check("R4 pin_oe", {24'h0, pin_oe}, 32'h0F);
    check("R6 alt_sel", {24'h0, alt_sel}, 32'h5A);

    // R8: read data holds through idle cycles
    repeat (4) @(negedge clk);
    check("R8 rdata hold", bus_rdata, 32'h0);

    // R5: writes to input lines are dropped
    bus_wr(12'h3FC, 32'h0000_00F0);
    check("R5 low nibble", {24'h0, pin_out}, 32'h00);
    bus_wr(12'h400, 32'h0000_00FF);
    check("R5 after turning outputs", {24'h0, pin_out}, 32'h00);

    // R9: only low byte of write used
    bus_wr(12'h420, 32'hFFFF_FF33);
    check("R9 alt low byte", {24'h0, alt_sel}, 32'h33);

    // R10: two-edge input latency
    bus_wr(12'h400, 32'h0);
    @(negedge clk);
    pin_in = 8'h3C;
    @(negedge clk);
    check("R10 after one edge", {24'h0, pin_state}, 32'hA5);
    @(negedge clk);
    check("R10 after two edges", {24'h0, pin_state}, 32'h3C);
    bus_rd(12'h3FC, rd);
    check("R10 data read", rd, 32'h3C);

    // R11: select strobe for interrupt range
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 12'h410;
    #1 check("R11 in range", {31'h0, ext_sel}, 32'h1);
    bus_addr = 12'h41C;
    #0.5 check("R11 top of range", {31'h0, ext_sel}, 32'h1);
    bus_addr = 12'h420;
    #0.5 check("R11 outside", {31'h0, ext_sel}, 32'h0);
    bus_valid = 1'b0;

    // R1: reset in mid-run clears configured state
    bus_wr(12'h400, 32'h0000_00FF);
    bus_wr(12'h3FC, 32'h0000_0081);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 pin_oe after reset", {24'h0, pin_oe}, 32'h0);
    check("R1 pin_out after reset", {24'h0, pin_out}, 32'h0);
    check("R1 alt after reset", {24'h0, alt_sel}, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule